// File: doc/BRIEF.md
# Linked Command List Executor

This block walks a chain of command blocks kept in a 16-bit word memory. The memory is reached through a single request port that carries one access at a time. A start pulse gives the address of the first block. For each block the walker marks it busy, reads its command word and carries out the action the opcode calls for. It then marks the block finished and fetches the 32-bit link to the next block.

Two actions keep state in the block. One loads a station address into a register. The other copies a clamped number of configuration bytes into a byte array. A third action writes the current link state back into the command block. All other opcodes finish with no action. Control bits in each command word decide three things: whether the walk stops after that block, whether the unit parks in a suspended state, and whether a completion interrupt is raised.

The memory is addressed in bytes, and every access is one aligned 16-bit word. In each word, the byte at the even address sits in bits 7:0 and the byte at the odd address sits in bits 15:8. The state code is 0 for idle, 1 for suspended and 2 for active.

Top module: `clw_walker`

## Requirements
- R1: While reset is held, the state code is 0 (idle). In that state mem_req, cx_flag, irq, evt_stop and evt_suspend are low, and ia_addr and cfg_bytes are all zero.
- R2: A start with a usable head makes the state code 2. The first access writes 0x4000 (busy, bit 14) to head+0, and the next access reads the command word at head+2, whose bits 2:0 are the opcode.
- R3: After the opcode's action, the walker writes 0xA000 (complete bit 15, OK bit 13) to block+0. It then reads the link low half at block+4 and the high half at block+6. If the walk goes on, the next access is the busy write at the linked address.
- R4: A request holds mem_req, mem_we, mem_addr and mem_wdata unchanged until mem_ack is seen, and the walker waits for that acknowledge before it issues the next access.
- R5: A link of 0x00000000 or 0xFFFFFFFF ends the walk. The state code returns to 0, evt_stop pulses for one cycle and no further request is made.
- R6: Command bit 15 ends the walk after the current block even when its link is valid.
- R7: Command bit 14 stops the walk after the current block. It sets the state code to 1 and pulses evt_suspend, and this takes precedence over bit 15. A later start resumes walking at the head it gives.
- R8: When a block completes with command bit 13 set, cx_flag is set and irq pulses once. When bit 13 is clear, cx_flag is cleared and irq stays low.
- R9: Opcode 1 reads the three words at +8, +10 and +12 into ia_addr. The byte at block+8 goes to ia_addr[7:0], and each following byte goes to the next higher 8 bits.
- R10: For opcode 2, the count is the low nibble of the byte at +8, raised to 4 if smaller and cut to CFG_BYTES if larger. Exactly that many bytes, starting at +8, go into cfg_bytes (byte k at bits 8k+7:8k). Only the words holding them are read, and the bytes above the count keep their old values.
- R11: Opcode 5 writes 0x8000 to +8 when link_up is high, or 0x0000 when it is low, and then writes 0x0000 to +10.
- R12: Opcodes 0, 3, 4, 6 and 7 make no access beyond the busy write, the command read, the completion write and the two link reads.
- R13: A start whose head is 0 or all ones makes no memory access. evt_stop pulses and the state code becomes 0.
- R14: A start pulse while the state code is 2 is ignored, and the walk in progress goes on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin or resume a walk at head_ptr |
| head_ptr | input | AW | Byte address of the first command block |
| link_up | input | 1 | Current link state, reported by opcode 5 |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the word accessed |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted (and read data valid) |
| cu_state | output | 2 | 0 idle, 1 suspended, 2 active |
| cx_flag | output | 1 | Command-complete event flag |
| irq | output | 1 | One-cycle interrupt request |
| evt_stop | output | 1 | One-cycle pulse when a walk ends |
| evt_suspend | output | 1 | One-cycle pulse when the unit suspends |
| ia_addr | output | 8*IA_BYTES | Loaded station address |
| cfg_bytes | output | 8*CFG_BYTES | Configuration byte array |

## Verification
The hardest case to reach from the ports is configure at both clamp limits. The first argument word carries the byte count and the first data bytes at once, so the word count is fixed only as that word is acknowledged. The bench sets nibble values of 1 and 15, puts guard words past the expected end, and checks the logged access count. It also checks that bytes above a short count keep the previous block's values. Ignored starts are tested by pulsing start in the middle of a walk that a memory with several wait cycles keeps going.

// File: rtl/clw_pkg.sv
package clw_pkg;

   typedef enum logic [1:0] {
      CU_IDLE   = 2'd0,
      CU_SUSP   = 2'd1,
      CU_ACTIVE = 2'd2
   } cu_state_e;

   typedef enum logic [3:0] {
      W_IDLE,
      W_BUSY,
      W_CMD,
      W_ARG,
      W_LT0,
      W_LT1,
      W_DONE,
      W_LLO,
      W_LHI
   } walk_e;

   localparam logic [15:0] STAT_BUSY_W = 16'h4000;
   localparam logic [15:0] STAT_FIN_W  = 16'hA000;
   localparam logic [15:0] LINK_UP_W   = 16'h8000;

   localparam logic [2:0] OP_SETADDR  = 3'd1;
   localparam logic [2:0] OP_CONFIG   = 3'd2;
   localparam logic [2:0] OP_LINKTEST = 3'd5;

   localparam int OFS_STAT = 0;
   localparam int OFS_CMD  = 2;
   localparam int OFS_LLO  = 4;
   localparam int OFS_LHI  = 6;
   localparam int OFS_ARG  = 8;
   localparam int OFS_ARG2 = 10;

   localparam int CFG_MIN = 4;

endpackage

// File: rtl/clw_link_decode.sv
module clw_link_decode (
   input  logic [31:0] link_i,
   output logic        is_end_o
);
   assign is_end_o = (link_i == 32'h0000_0000) || (&link_i);
endmodule

// File: rtl/clw_byte_bank.sv
module clw_byte_bank #(
   parameter int NBYTES = 6,
   parameter int IDXW   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDXW-1:0]     wr_idx,
   input  logic [IDXW-1:0]     wr_lim,
   input  logic [15:0]         wr_data,
   output logic [NBYTES*8-1:0] bytes_o
);

   if (NBYTES < 1) begin : g_bad_nbytes
      $error("clw_byte_bank: NBYTES must be at least 1");
   end
   if ((1 << IDXW) < NBYTES + 2) begin : g_bad_idxw
      $error("clw_byte_bank: IDXW too narrow for NBYTES");
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      logic [7:0] b_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            b_q <= 8'h00;
         end else if (wr_en && (g < int'(wr_lim))) begin
            if (int'(wr_idx) == g) begin
               b_q <= wr_data[7:0];
            end else if (int'(wr_idx) + 1 == g) begin
               b_q <= wr_data[15:8];
            end
         end
      end
      assign bytes_o[g*8 +: 8] = b_q;
   end

   AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < NBYTES)); // R10

endmodule

// File: rtl/clw_walker.sv
module clw_walker
   import clw_pkg::*;
#(
   parameter int AW        = 32,
   parameter int CFG_BYTES = 14,
   parameter int IA_BYTES  = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   start,
   input  logic [AW-1:0]          head_ptr,
   input  logic                   link_up,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [AW-1:0]          mem_addr,
   output logic [15:0]            mem_wdata,
   input  logic [15:0]            mem_rdata,
   input  logic                   mem_ack,
   output logic [1:0]             cu_state,
   output logic                   cx_flag,
   output logic                   irq,
   output logic                   evt_stop,
   output logic                   evt_suspend,
   output logic [IA_BYTES*8-1:0]  ia_addr,
   output logic [CFG_BYTES*8-1:0] cfg_bytes
);

   localparam int IA_WORDS = IA_BYTES / 2;
   localparam int MAXB     = (CFG_BYTES > IA_BYTES) ? CFG_BYTES : IA_BYTES;
   localparam int IDXW     = $clog2(MAXB + 2);

   if (AW < 4 || AW > 32) begin : g_bad_aw
      $error("clw_walker: AW must lie in 4..32");
   end
   if (CFG_BYTES < CFG_MIN) begin : g_bad_cfg
      $error("clw_walker: CFG_BYTES below the minimum copy count");
   end
   if (IA_BYTES < 2 || (IA_BYTES % 2) != 0) begin : g_bad_ia
      $error("clw_walker: IA_BYTES must be even and nonzero");
   end

   walk_e          walk_q;
   cu_state_e      cu_q;
   logic [AW-1:0]  ptr_q;
   logic [2:0]     op_q;
   logic [2:0]     ctl_q;      // [2] end of list, [1] suspend, [0] interrupt
   logic [IDXW-1:0] arg_q;
   logic [IDXW-1:0] lim_q;
   logic [15:0]    link_lo_q;
   logic           lnk_q;
   logic           cx_q, irq_q, stop_q, susp_q;

   logic [AW-1:0]  off_c;
   logic [31:0]    next_link;
   logic           link_end;
   logic           head_null;
   logic [IDXW-1:0] lim_first, lim_cur, byte_idx;
   logic           arg_last;
   logic           ia_wr, cfg_wr;
   int             nib_i, lim_i, words_i;

   // ---------------- memory request decode ----------------
   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = 16'h0000;
      off_c     = AW'(OFS_STAT);
      unique case (walk_q)
         W_BUSY: begin
            mem_we    = 1'b1;
            mem_wdata = STAT_BUSY_W;
         end
         W_CMD:  off_c = AW'(OFS_CMD);
         W_ARG:  off_c = AW'(OFS_ARG + 2 * int'(arg_q));
         W_LT0: begin
            mem_we    = 1'b1;
            off_c     = AW'(OFS_ARG);
            mem_wdata = lnk_q ? LINK_UP_W : 16'h0000;
         end
         W_LT1: begin
            mem_we    = 1'b1;
            off_c     = AW'(OFS_ARG2);
         end
         W_DONE: begin
            mem_we    = 1'b1;
            mem_wdata = STAT_FIN_W;
         end
         W_LLO:  off_c = AW'(OFS_LLO);
         W_LHI:  off_c = AW'(OFS_LHI);
         default: ;
      endcase
   end

   assign mem_req  = (walk_q != W_IDLE);
   assign mem_addr = ptr_q + off_c;

   // ---------------- argument count and configure clamp ----------------
   always_comb begin
      nib_i = int'(mem_rdata[3:0]);
      lim_i = (nib_i < CFG_MIN) ? CFG_MIN : nib_i;
      if (lim_i > CFG_BYTES) begin
         lim_i = CFG_BYTES;
      end
      lim_first = IDXW'(lim_i);
      lim_cur   = (arg_q == '0) ? lim_first : lim_q;
      words_i   = (op_q == OP_CONFIG) ? ((int'(lim_cur) + 1) / 2) : IA_WORDS;
      arg_last  = (int'(arg_q) + 1) >= words_i;
   end

   assign byte_idx = IDXW'(2 * int'(arg_q));
   assign ia_wr    = (walk_q == W_ARG) && mem_ack && (op_q == OP_SETADDR);
   assign cfg_wr   = (walk_q == W_ARG) && mem_ack && (op_q == OP_CONFIG);

   clw_byte_bank #(.NBYTES(IA_BYTES), .IDXW(IDXW)) u_ia_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ia_wr),
      .wr_idx  (byte_idx),
      .wr_lim  (IDXW'(IA_BYTES)),
      .wr_data (mem_rdata),
      .bytes_o (ia_addr)
   );

   clw_byte_bank #(.NBYTES(CFG_BYTES), .IDXW(IDXW)) u_cfg_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr),
      .wr_idx  (byte_idx),
      .wr_lim  (lim_cur),
      .wr_data (mem_rdata),
      .bytes_o (cfg_bytes)
   );

   // ---------------- link handling ----------------
   assign next_link = {mem_rdata, link_lo_q};
   assign head_null = (head_ptr == '0) || (&head_ptr);

   clw_link_decode u_link_dec (
      .link_i   (next_link),
      .is_end_o (link_end)
   );

   // ---------------- walker sequence ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         walk_q    <= W_IDLE;
         cu_q      <= CU_IDLE;
         ptr_q     <= '0;
         op_q      <= 3'd0;
         ctl_q     <= 3'd0;
         arg_q     <= '0;
         lim_q     <= '0;
         link_lo_q <= 16'h0000;
         lnk_q     <= 1'b0;
         cx_q      <= 1'b0;
         irq_q     <= 1'b0;
         stop_q    <= 1'b0;
         susp_q    <= 1'b0;
      end else begin
         irq_q  <= 1'b0;
         stop_q <= 1'b0;
         susp_q <= 1'b0;
         unique case (walk_q)
            W_IDLE: begin
               if (start) begin
                  if (head_null) begin
                     stop_q <= 1'b1;
                     cu_q   <= CU_IDLE;
                  end else begin
                     ptr_q  <= head_ptr;
                     cu_q   <= CU_ACTIVE;
                     walk_q <= W_BUSY;
                  end
               end
            end
            W_BUSY: if (mem_ack) walk_q <= W_CMD;
            W_CMD: begin
               if (mem_ack) begin
                  op_q  <= mem_rdata[2:0];
                  ctl_q <= mem_rdata[15:13];
                  arg_q <= '0;
                  lnk_q <= link_up;
                  case (mem_rdata[2:0])
                     OP_SETADDR, OP_CONFIG: walk_q <= W_ARG;
                     OP_LINKTEST:           walk_q <= W_LT0;
                     default:               walk_q <= W_DONE;
                  endcase
               end
            end
            W_ARG: begin
               if (mem_ack) begin
                  if (arg_q == '0) lim_q <= lim_first;
                  if (arg_last) walk_q <= W_DONE;
                  else          arg_q  <= arg_q + 1'b1;
               end
            end
            W_LT0:  if (mem_ack) walk_q <= W_LT1;
            W_LT1:  if (mem_ack) walk_q <= W_DONE;
            W_DONE: if (mem_ack) walk_q <= W_LLO;
            W_LLO: begin
               if (mem_ack) begin
                  link_lo_q <= mem_rdata;
                  walk_q    <= W_LHI;
               end
            end
            W_LHI: begin
               if (mem_ack) begin
                  cx_q  <= ctl_q[0];
                  irq_q <= ctl_q[0];
                  if (ctl_q[1]) begin
                     cu_q   <= CU_SUSP;
                     susp_q <= 1'b1;
                     walk_q <= W_IDLE;
                  end else if (ctl_q[2] || link_end) begin
                     cu_q   <= CU_IDLE;
                     stop_q <= 1'b1;
                     walk_q <= W_IDLE;
                  end else begin
                     ptr_q  <= next_link[AW-1:0];
                     walk_q <= W_BUSY;
                  end
               end
            end
            default: walk_q <= W_IDLE;
         endcase
      end
   end

   assign cu_state    = cu_q;
   assign cx_flag     = cx_q;
   assign irq         = irq_q;
   assign evt_stop    = stop_q;
   assign evt_suspend = susp_q;

   // ---------------- assertions ----------------
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata))); // R4
   AST_BUSY_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> (mem_we && mem_wdata == 16'h4000)); // R2
   AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (cu_state != 2'd2) |-> !mem_req); // R5
   AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_stop |-> (cu_state == 2'd0)); // R5
   AST_SUSP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      evt_suspend |-> (cu_state == 2'd1)); // R7
   AST_EVT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({evt_stop, evt_suspend})); // R6
   AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> cx_flag); // R8

endmodule

// File: tb/test_clw_walker.sv
module test_clw_walker;
   localparam int CLK_PERIOD = 10;
   localparam int CFGN = 14;
   localparam int IAN  = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] head = 32'h0;
   logic        link_up = 1'b1;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [15:0] mem_wdata;
   logic [15:0] mem_rdata = 16'h0;
   logic        mem_ack = 1'b0;
   logic [1:0]  cu_state;
   logic        cx_flag, irq, evt_stop, evt_suspend;
   logic [IAN*8-1:0]  ia_addr;
   logic [CFGN*8-1:0] cfg_bytes;

   logic [15:0] mem [0:1023];
   logic [31:0] log_addr [0:63];
   logic        log_we   [0:63];
   logic [15:0] log_dat  [0:63];
   int log_n = 0;
   int lat = 0;
   int wait_cnt = 0;
   int n_checks = 0, n_fail = 0;
   int n_stop = 0, n_susp = 0, n_irq = 0;
   int hold_viol = 0;
   logic        pv_pend = 1'b0;
   logic [31:0] pv_addr = 32'h0;
   logic        pv_we = 1'b0;
   logic [15:0] pv_wd = 16'h0;
   bit done = 1'b0;

   clw_walker #(.AW(32), .CFG_BYTES(CFGN), .IA_BYTES(IAN)) i_clw_walker (
      .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head), .link_up(link_up),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .mem_ack(mem_ack), .cu_state(cu_state), .cx_flag(cx_flag),
      .irq(irq), .evt_stop(evt_stop), .evt_suspend(evt_suspend),
      .ia_addr(ia_addr), .cfg_bytes(cfg_bytes)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // memory model with a hold monitor; serves one request after lat wait cycles
   always @(negedge clk) begin
      if (pv_pend && (!mem_req || mem_addr != pv_addr || mem_we != pv_we || mem_wdata != pv_wd))
         hold_viol++;
      if (mem_ack) begin
         mem_ack = 1'b0;
      end else if (mem_req) begin
         if (wait_cnt < lat) begin
            wait_cnt++;
         end else begin
            wait_cnt = 0;
            if (mem_we) mem[mem_addr[10:1]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[10:1]];
            if (log_n < 64) begin
               log_addr[log_n] = mem_addr;
               log_we[log_n]   = mem_we;
               log_dat[log_n]  = mem_we ? mem_wdata : 16'h0;
            end
            log_n++;
            mem_ack = 1'b1;
         end
      end
      pv_pend = mem_req && !mem_ack;
      pv_addr = mem_addr;
      pv_we   = mem_we;
      pv_wd   = mem_wdata;
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_stop)    n_stop++;
         if (evt_suspend) n_susp++;
         if (irq)         n_irq++;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_log(input int i, input string tag, input logic we,
                          input logic [31:0] a, input logic [15:0] d);
      chk(tag, log_addr[i], a);
      chk(tag, log_we[i], we);
      if (we) chk(tag, log_dat[i], d);
   endtask

   task automatic put_block(input logic [31:0] a, input logic [15:0] cmd, input logic [31:0] lnk);
      mem[a[10:1]]        = 16'hDEAD;
      mem[(a + 2) >> 1]   = cmd;
      mem[(a + 4) >> 1]   = lnk[15:0];
      mem[(a + 6) >> 1]   = lnk[31:16];
   endtask

   task automatic run(input logic [31:0] h);
      log_n = 0;
      @(negedge clk);
      head  = h;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3000) begin
         if (cu_state != 2'd2) break;
         @(negedge clk);
      end
      @(negedge clk);
   endtask

   function automatic logic [7:0] cfgb(input int k);
      return cfg_bytes[k*8 +: 8];
   endfunction

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   task automatic t_reset();
      chk("R1 state", cu_state, 2'd0);
      chk("R1 req", mem_req, 1'b0);
      chk("R1 cx", cx_flag, 1'b0);
      chk("R1 irq", irq, 1'b0);
      chk("R1 stop", evt_stop, 1'b0);
      chk("R1 susp", evt_suspend, 1'b0);
      chk("R1 ia", ia_addr, 48'h0);
      chk("R1 cfg lo", cfg_bytes[63:0], 64'h0);
      chk("R1 cfg hi", cfg_bytes[CFGN*8-1:64], 64'h0);
   endtask

   task automatic t_single_nop();
      int s0;
      lat = 0;
      s0 = n_stop;
      put_block(32'h100, 16'h8000, 32'h0000_0200);   // end-of-list with a valid link
      run(32'h100);
      chk("R2 R12 count", log_n, 5);
      chk_log(0, "R2 busy write", 1'b1, 32'h100, 16'h4000);
      chk_log(1, "R2 cmd read", 1'b0, 32'h102, 16'h0);
      chk_log(2, "R3 done write", 1'b1, 32'h100, 16'hA000);
      chk_log(3, "R3 link lo", 1'b0, 32'h104, 16'h0);
      chk_log(4, "R3 link hi", 1'b0, 32'h106, 16'h0);
      chk("R6 stop", n_stop - s0, 1);
      chk("R6 state", cu_state, 2'd0);
      chk("R3 status", mem[12'h100 >> 1], 16'hA000);
   endtask

   task automatic t_chain();
      int s0, i0;
      lat = 3;
      link_up = 1'b1;
      s0 = n_stop;
      i0 = n_irq;
      hold_viol = 0;
      put_block(32'h100, 16'h0005, 32'h0000_0140);
      mem[12'h108 >> 1] = 16'h1234;
      mem[12'h10A >> 1] = 16'h5678;
      put_block(32'h140, 16'h0001, 32'h0000_0180);
      mem[12'h148 >> 1] = 16'h2211;
      mem[12'h14A >> 1] = 16'h4433;
      mem[12'h14C >> 1] = 16'h6655;
      put_block(32'h180, 16'h2002, 32'hFFFF_FFFF);
      mem[12'h188 >> 1] = 16'h1106;
      mem[12'h18A >> 1] = 16'h2233;
      mem[12'h18C >> 1] = 16'h4455;
      mem[12'h18E >> 1] = 16'hEEEE;
      run(32'h100);
      chk("R3 count", log_n, 23);
      chk_log(7, "R3 next busy", 1'b1, 32'h140, 16'h4000);
      chk("R11 up word", mem[12'h108 >> 1], 16'h8000);
      chk("R11 hi word", mem[12'h10A >> 1], 16'h0000);
      chk("R9 ia", ia_addr, 48'h6655_4433_2211);
      chk("R10 b0", cfgb(0), 8'h06);
      chk("R10 b1", cfgb(1), 8'h11);
      chk("R10 b3", cfgb(3), 8'h22);
      chk("R10 b5", cfgb(5), 8'h44);
      chk("R10 b6 untouched", cfgb(6), 8'h00);
      chk("R8 cx set", cx_flag, 1'b1);
      chk("R8 irq once", n_irq - i0, 1);
      chk("R5 all-ones link stop", n_stop - s0, 1);
      chk("R5 state", cu_state, 2'd0);
      chk("R4 hold", hold_viol, 0);
      chk("R3 status B", mem[12'h140 >> 1], 16'hA000);
   endtask

   task automatic t_cfg_low();
      int i0;
      lat = 1;
      i0 = n_irq;
      put_block(32'h200, 16'h8002, 32'h0000_0300);
      mem[12'h208 >> 1] = 16'h7701;
      mem[12'h20A >> 1] = 16'h9988;
      mem[12'h20C >> 1] = 16'hCCCC;
      run(32'h200);
      chk("R10 low clamp count", log_n, 7);
      chk("R10 b0", cfgb(0), 8'h01);
      chk("R10 b1", cfgb(1), 8'h77);
      chk("R10 b2", cfgb(2), 8'h88);
      chk("R10 b3", cfgb(3), 8'h99);
      chk("R10 b4 kept", cfgb(4), 8'h55);
      chk("R10 b5 kept", cfgb(5), 8'h44);
      chk("R8 cx cleared", cx_flag, 1'b0);
      chk("R8 no irq", n_irq - i0, 0);
   endtask

   task automatic t_cfg_high();
      lat = 0;
      put_block(32'h300, 16'h8002, 32'h0000_0100);
      mem[12'h308 >> 1] = 16'hA10F;
      for (int k = 1; k < 7; k++)
         mem[(12'h308 >> 1) + k] = {8'(8'hB0 + 2*k + 1), 8'(8'hB0 + 2*k)};
      mem[12'h316 >> 1] = 16'hFFFF;
      run(32'h300);
      chk("R10 high clamp count", log_n, 12);
      chk("R10 b0", cfgb(0), 8'h0F);
      chk("R10 b1", cfgb(1), 8'hA1);
      chk("R10 b2", cfgb(2), 8'hB2);
      chk("R10 b13", cfgb(13), 8'hBD);
   endtask

   task automatic t_suspend();
      int s0, p0;
      lat = 2;
      s0 = n_stop;
      p0 = n_susp;
      put_block(32'h400, 16'hC000, 32'h0000_0440);   // suspend and end-of-list both set
      put_block(32'h440, 16'h8000, 32'h0000_0000);
      run(32'h400);
      chk("R7 count", log_n, 5);
      chk("R7 state", cu_state, 2'd1);
      chk("R7 susp evt", n_susp - p0, 1);
      chk("R7 no stop", n_stop - s0, 0);
      run(32'h440);
      chk_log(0, "R7 resume", 1'b1, 32'h440, 16'h4000);
      chk("R7 resumed end", cu_state, 2'd0);
      chk("R7 stop evt", n_stop - s0, 1);
   endtask

   task automatic t_zero_link();
      int s0;
      lat = 0;
      link_up = 1'b0;
      s0 = n_stop;
      put_block(32'h480, 16'h0005, 32'h0000_0000);
      mem[12'h488 >> 1] = 16'h1234;
      mem[12'h48A >> 1] = 16'h5678;
      run(32'h480);
      chk("R11 down count", log_n, 7);
      chk("R11 down word", mem[12'h488 >> 1], 16'h0000);
      chk("R11 hi word", mem[12'h48A >> 1], 16'h0000);
      chk("R5 zero link stop", n_stop - s0, 1);
      chk("R5 state", cu_state, 2'd0);
      link_up = 1'b1;
   endtask

   task automatic t_null_head();
      int s0;
      s0 = n_stop;
      run(32'hFFFF_FFFF);
      chk("R13 no access", log_n, 0);
      chk("R13 stop", n_stop - s0, 1);
      chk("R13 state", cu_state, 2'd0);
   endtask

   task automatic t_busy_start();
      int s0, bad;
      lat = 4;
      s0 = n_stop;
      bad = 0;
      put_block(32'h100, 16'h8000, 32'h0000_0200);
      put_block(32'h500, 16'h8000, 32'h0000_0000);
      log_n = 0;
      @(negedge clk);
      head = 32'h100;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (5) @(negedge clk);
      head = 32'h500;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3000) begin
         if (cu_state != 2'd2) break;
         @(negedge clk);
      end
      @(negedge clk);
      for (int i = 0; i < log_n && i < 64; i++)
         if (log_addr[i][11:8] == 4'h5) bad++;
      chk("R14 no foreign access", bad, 0);
      chk("R14 count", log_n, 5);
      chk("R14 one stop", n_stop - s0, 1);
   endtask

   task automatic t_other_ops();
      logic [2:0] ops [0:3];
      ops[0] = 3'd3; ops[1] = 3'd4; ops[2] = 3'd6; ops[3] = 3'd7;
      lat = 1;
      for (int j = 0; j < 4; j++) begin
         put_block(32'h600, {13'h1000, ops[j]}, 32'h0000_0100);
         mem[12'h608 >> 1] = 16'h5A5A;
         run(32'h600);
         chk("R12 count", log_n, 5);
         chk_log(2, "R12 done write", 1'b1, 32'h600, 16'hA000);
         chk("R12 arg untouched", mem[12'h608 >> 1], 16'h5A5A);
      end
   endtask

   initial begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_single_nop();
      t_chain();
      t_cfg_low();
      t_cfg_high();
      t_suspend();
      t_zero_link();
      t_null_head();
      t_busy_start();
      t_other_ops();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         report();
         $finish;
      end
   end

endmodule